// File: doc/BRIEF.md
# Half-Precision Round-to-Integral Unit

This unit takes a 64-bit floating-point register word that should carry a half-precision value in its low 16 bits. It first checks that the word is properly boxed, then rounds the half-precision value to an integral value under one of five rounding modes. The integral result is returned as a half-precision number, boxed back into 64 bits, together with a five-bit exception flag vector.

A word whose upper 48 bits are not all ones is not read as its low half. It is replaced by the canonical quiet NaN before rounding. The unit is a single pipeline stage. Each request strobe produces exactly one response in the following cycle. The output side has no ready signal, so the consumer must take every response in the cycle it appears. This is the only back-pressure rule: there is none, and the producer may issue a new request in every cycle.

Top module: `hround_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. `out_res` and `out_flags` carry that request's result in the same cycle. After reset, `out_valid`, `out_res` and `out_flags` are all zero.
- R2: The operand counts as boxed only when bits 63:16 are all ones. Given a legal rounding mode, an unboxed operand yields the canonical NaN 0x7E00 in the low half with all flags clear, whatever its low 16 bits hold.
- R3: Whenever `out_valid` is high, bits 63:16 of `out_res` are all ones.
- R4: The rounding modes are encoded 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest with ties away from zero. The result is the integral value that the selected mode picks, and a carry out of the fraction raises the exponent (3.5 under nearest-even gives 4.0, 0x4400).
- R5: A rounding mode of 101, 110 or 111 yields 0x7E00 with the invalid flag set, whatever the operand holds.
- R6: Any NaN input yields 0x7E00. A signaling NaN (exponent all ones, nonzero fraction, fraction bit 9 clear) also sets the invalid flag. A quiet NaN sets no flag.
- R7: Infinities, signed zeros and finite values whose unbiased exponent is 10 or more are returned unchanged, with no flag set.
- R8: The inexact flag is set exactly when the result differs from the input value. A result of zero magnitude keeps the input's sign, so -0.3 under nearest-even gives -0.0 (0x8000).
- R9: The flag vector is ordered, from bit 4 down to bit 0: invalid, divide-by-zero, overflow, underflow, inexact. Bits 3 to 1 are always zero.
- R10: In cycles after which no request was accepted, `out_res` and `out_flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_opnd | input | 64 | Boxed half-precision operand |
| in_rm | input | 3 | Rounding mode |
| out_valid | output | 1 | Response strobe, one cycle after the request |
| out_res | output | 64 | Boxed half-precision integral result |
| out_flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
The assertions assume that `in_valid`, `in_opnd` and `in_rm` are driven to known values from reset onward. They also assume that the consumer needs no stall, because the unit has no way to hold a response back. The stimulus drives every input at the falling edge, keeps `in_valid` low throughout reset, and sends requests both back to back and with idle gaps between them. This exercises the hold behaviour as well as one-per-cycle throughput. Operands cover legal and illegal box patterns, all eight rounding-mode codes, subnormals, half-way ties and the largest fractional magnitudes, all with known expected values.

// File: rtl/hround_pkg.sv
package hround_pkg;
  parameter int FLEN  = 64;
  parameter int HLEN  = 16;
  parameter int EXP_W = 5;
  parameter int MAN_W = 10;
  parameter int FLG_W = 5;

  localparam int BOX_W = FLEN - HLEN;
  localparam int MAG_W = HLEN - 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  localparam logic [HLEN-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [MAG_W-1:0] MAG_ONE  = {1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_ZERO      = 3'b001,
    RM_DOWN      = 3'b010,
    RM_UP        = 3'b011,
    RM_NEAR_MAX  = 3'b100
  } rmode_e;

  localparam int FLG_NV = 4;
  localparam int FLG_NX = 0;
endpackage

// File: rtl/hround_unbox.sv
module hround_unbox
  import hround_pkg::*;
(
  input  logic [FLEN-1:0] opnd,
  output logic [HLEN-1:0] half,
  output logic            boxed
);
  always_comb begin
    boxed = &opnd[FLEN-1:HLEN];
    half  = boxed ? opnd[HLEN-1:0] : CANON_NAN;
  end
endmodule

// File: rtl/hround_core.sv
module hround_core
  import hround_pkg::*;
(
  input  logic [HLEN-1:0]  half,
  input  logic [2:0]       rm,
  output logic [HLEN-1:0]  res,
  output logic [FLG_W-1:0] flags
);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_INT  = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_UNIT = EXP_W'(BIAS);

  logic                sgn;
  logic [EXP_W-1:0]    ex;
  logic [MAN_W-1:0]    fr;
  logic [MAG_W-1:0]    mag;
  logic [EXP_W-1:0]    k;
  logic [MAG_W-1:0]    unit, mask, halfpt, rem, trunc;
  logic                rem_nz, gt_half, eq_half, lsb, inc, rm_ok;

  assign sgn = half[HLEN-1];
  assign ex  = half[HLEN-2:MAN_W];
  assign fr  = half[MAN_W-1:0];
  assign mag = half[MAG_W-1:0];

  // Fraction width below the binary point for exponents in the rounding range.
  always_comb begin
    k      = EXP_INT - ex;
    unit   = MAG_W'(1) << k;
    mask   = unit - MAG_W'(1);
    halfpt = MAG_W'(1) << (k - EXP_W'(1));
    rem    = mag & mask;
    trunc  = mag & ~mask;
  end

  // Round-direction decision shared by the fractional and the sub-unit cases.
  always_comb begin
    if (ex < EXP_UNIT) begin
      rem_nz  = |mag;
      gt_half = (ex == EXP_HALF) && (|fr);
      eq_half = (ex == EXP_HALF) && !(|fr);
      lsb     = 1'b0;
    end else begin
      rem_nz  = |rem;
      gt_half = rem > halfpt;
      eq_half = rem == halfpt;
      lsb     = |(mag & unit);
    end
    rm_ok = 1'b1;
    unique case (rm)
      RM_NEAR_EVEN: inc = gt_half || (eq_half && lsb);
      RM_ZERO:      inc = 1'b0;
      RM_DOWN:      inc = rem_nz && sgn;
      RM_UP:        inc = rem_nz && !sgn;
      RM_NEAR_MAX:  inc = gt_half || eq_half;
      default: begin
        inc   = 1'b0;
        rm_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    res   = half;
    flags = '0;
    if (!rm_ok) begin
      res           = CANON_NAN;
      flags[FLG_NV] = 1'b1;
    end else if (ex == EXP_ONES) begin
      if (|fr) begin
        res           = CANON_NAN;
        flags[FLG_NV] = !fr[MAN_W-1];
      end
    end else if (ex >= EXP_INT) begin
      res = half;
    end else if (ex < EXP_UNIT) begin
      if (rem_nz) begin
        res           = {sgn, inc ? MAG_ONE : {MAG_W{1'b0}}};
        flags[FLG_NX] = 1'b1;
      end
    end else begin
      res           = {sgn, trunc + (inc ? unit : {MAG_W{1'b0}})};
      flags[FLG_NX] = rem_nz;
    end
  end
endmodule

// File: rtl/hround_unit.sv
module hround_unit
  import hround_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      in_opnd,
  input  logic [2:0]       in_rm,
  output logic             out_valid,
  output logic [63:0]      out_res,
  output logic [4:0]       out_flags
);
  logic [HLEN-1:0]  half;
  logic             boxed;
  logic [HLEN-1:0]  core_res;
  logic [FLG_W-1:0] core_flags;
  logic [FLEN-1:0]  boxed_res;

  hround_unbox u_unbox (
    .opnd  (in_opnd),
    .half  (half),
    .boxed (boxed)
  );

  hround_core u_core (
    .half  (half),
    .rm    (in_rm),
    .res   (core_res),
    .flags (core_flags)
  );

  assign boxed_res = {{BOX_W{1'b1}}, core_res};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= boxed_res;
        out_flags <= core_flags;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_UNBOXED_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !boxed && in_rm <= 3'd4) |=> (out_res[15:0] == 16'h7E00 && out_flags == 5'd0)); // R2
  AST_OUT_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&out_res[63:16])); // R3
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rm > 3'd4) |=> (out_res[15:0] == 16'h7E00 && out_flags == 5'b10000)); // R5
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_res[14:10]) && (|out_res[9:0])) |-> out_res[15:0] == 16'h7E00); // R6
  AST_NX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[0]) |-> !out_flags[4]); // R8
  AST_FLAG_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[3:1] == 3'b000); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_res) && $stable(out_flags))); // R10
endmodule

// File: tb/test_hround_unit.sv
`timescale 1ns/1ps
module test_hround_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_opnd = '0;
  logic [2:0]  in_rm = '0;
  logic        out_valid;
  logic [63:0] out_res;
  logic [4:0]  out_flags;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [68:0] exp_q[$];
  string       tag_q[$];

  localparam logic [47:0] BOX = 48'hFFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  hround_unit i_hround_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_opnd   (in_opnd),
    .in_rm     (in_rm),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_flags (out_flags)
  );

  task automatic check(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [63:0] op, input logic [2:0] rm,
                       input logic [15:0] er, input logic [4:0] ef, input string tag);
    in_opnd  = op;
    in_rm    = rm;
    in_valid = 1'b1;
    exp_q.push_back({BOX, er, ef});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a response appears.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected response", {out_res, out_flags}, '0);
      end else begin
        logic [68:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_res, out_flags} === e, t, {out_res, out_flags}, e);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        check(1'b0, "watchdog expired", '0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({out_valid, out_res, out_flags} === 70'd0, "R1 reset state",
          {out_res, out_flags}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // Back-to-back requests
    drive(64'h0, 3'd0, 16'h7E00, 5'h00, "R2 all-zero operand");
    drive({32'h0, 32'hFFFF_3C00}, 3'd0, 16'h7E00, 5'h00, "R2 upper word clear");
    drive({BOX - 48'd1, 16'h4100}, 3'd1, 16'h7E00, 5'h00, "R2 one box bit clear");
    drive({BOX, 16'h4100}, 3'd0, 16'h4000, 5'h01, "R4 2.5 near-even");
    drive({BOX, 16'h4100}, 3'd4, 16'h4200, 5'h01, "R4 2.5 ties-away");
    drive({BOX, 16'h4100}, 3'd3, 16'h4200, 5'h01, "R4 2.5 up");
    drive({BOX, 16'hC100}, 3'd2, 16'hC200, 5'h01, "R4 -2.5 down");
    drive({BOX, 16'hC100}, 3'd1, 16'hC000, 5'h01, "R4 -2.5 toward zero");
    drive({BOX, 16'h4300}, 3'd0, 16'h4400, 5'h01, "R4 3.5 carry into exponent");
    drive({BOX, 16'h3E00}, 3'd0, 16'h4000, 5'h01, "R4 1.5 near-even");
    idle();
    drive({BOX, 16'h5FFE}, 3'd0, 16'h6000, 5'h01, "R4 511.5 near-even");
    drive({BOX, 16'h3800}, 3'd0, 16'h0000, 5'h01, "R8 0.5 near-even to +0");
    drive({BOX, 16'h3800}, 3'd4, 16'h3C00, 5'h01, "R4 0.5 ties-away");
    drive({BOX, 16'hB4CD}, 3'd0, 16'h8000, 5'h01, "R8 -0.3 to -0");
    drive({BOX, 16'h34CD}, 3'd3, 16'h3C00, 5'h01, "R4 0.3 up");
    drive({BOX, 16'h0001}, 3'd3, 16'h3C00, 5'h01, "R4 subnormal up");
    drive({BOX, 16'h0001}, 3'd2, 16'h0000, 5'h01, "R4 subnormal down");
    drive({BOX, 16'h4500}, 3'd0, 16'h4500, 5'h00, "R8 5.0 exact");
    idle();
    idle();
    drive({BOX, 16'h6401}, 3'd3, 16'h6401, 5'h00, "R7 1025 passes");
    drive({BOX, 16'h7C00}, 3'd2, 16'h7C00, 5'h00, "R7 +inf passes");
    drive({BOX, 16'h8000}, 3'd3, 16'h8000, 5'h00, "R7 -0 passes");
    drive({BOX, 16'h7C01}, 3'd0, 16'h7E00, 5'h10, "R6 signaling NaN");
    drive({BOX, 16'hFE55}, 3'd1, 16'h7E00, 5'h00, "R6 quiet NaN");
    drive({BOX, 16'h4100}, 3'd5, 16'h7E00, 5'h10, "R5 mode 101");
    drive({BOX, 16'h4500}, 3'd6, 16'h7E00, 5'h10, "R5 mode 110");
    drive(64'h0, 3'd7, 16'h7E00, 5'h10, "R5 mode 111 unboxed");
    drive({BOX, 16'h8000}, 3'd0, 16'h8000, 5'h00, "R9 flags stay clear");
    drive({BOX, 16'h63FF}, 3'd0, 16'h6400, 5'h01, "R4 1023.5 near-even");
    idle();
    idle();
    check(out_valid === 1'b0, "R1 valid low when idle", {68'd0, out_valid}, '0);
    check({out_res, out_flags} === {BOX, 16'h6400, 5'h01}, "R10 result held",
          {out_res, out_flags}, {BOX, 16'h6400, 5'h01});
    idle();
    check(exp_q.size() == 0, "R1 all responses seen", 69'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule